// File: doc/BRIEF.md
# Double-Pumped Single-Port Register File

This block is the register store of a small processor core. It keeps its words in one single-port array and runs that array on a clock at twice the core rate. A core cycle is two fast cycles long. Core cycles alternate between an instruction/result cycle and an operand cycle, which gives four fixed array slots in every pair of core cycles. In order, they are: instruction fetch, result write, source operand read and destination operand read. Each read lands in a core-rate output register. That register stays constant for a whole core cycle after it is loaded.

An instruction occupies one instruction/result cycle followed by one operand cycle. Ordinary operand selectors are 9 bits wide, so on their own they reach only the bottom 512 words. An address-extension prefix can load full 11-bit source and destination addresses. Each address comes either from an immediate or from the low bits of an operand that the prefix instruction reads itself. While a prefix is pending, it replaces the operand addresses, so any ordinary instruction can reach the whole 2048-word space.

The core-rate inputs are sampled on `clk2x`. They must be set up at the start of each instruction and held until the instruction ends. The block reports its position in the schedule on `phase_sd` and `half_hi`.

Top module: `dpump_regfile`

## Requirements
- R1: While reset is low and after it is released, the schedule is in the instruction/result phase, first half (`phase_sd`=0, `half_hi`=0), and all three read outputs are zero.
- R2: `half_hi` toggles on every `clk2x` edge. `phase_sd` toggles on the edge that ends a second half, so slots run 0 (fetch), 1 (write), 2 (source), 3 (destination) with slot = {`phase_sd`,`half_hi`}.
- R3: A result write happens in slot 1 only when `res_we` is 1. With `res_we`=0 the addressed word keeps its value.
- R4: The source and destination words are read in slots 2 and 3. They appear together on `src_word`/`dst_word` at the edge that ends slot 3 and stay unchanged until the next such edge.
- R5: The instruction fetch reads the full 11-bit `fetch_addr` in slot 0. The word appears on `instr_word` at the edge that ends slot 1 and stays unchanged until the next such edge.
- R6: Within one instruction, the fetch sees the value stored before that instruction's write, and both operand reads see the newly written value.
- R7: With no prefix pending, operand addresses are `src_sel`/`dst_sel` zero-extended to 11 bits.
- R8: An instruction with `ext_load`=1 arms a prefix when it ends. Its source/destination addresses are `ext_src_imm`/`ext_dst_imm` when the matching from-register flag is 0. While the prefix is pending, these addresses replace the operand addresses of every following instruction.
- R9: A pending prefix clears at the end of the first instruction with `op_consume`=1 and `ext_load`=0. Instructions with `op_consume`=0 leave it pending.
- R10: A from-register flag of 1 takes the prefix address from bits [10:0] of the word that the prefix instruction itself reads on that operand. The prefix instruction's own operands always use the plain 9-bit selectors, even while another prefix is pending.
- R11: A second prefix that arrives before any consuming instruction replaces the first.
- R12: Reset clears any pending prefix.
- R13: The array is written only in slot 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Fast clock, twice the core rate |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_sd | output | 1 | 0 in the instruction/result core cycle, 1 in the operand cycle |
| half_hi | output | 1 | 1 in the second fast cycle of a core cycle |
| fetch_addr | input | 11 | Instruction fetch address |
| res_we | input | 1 | Result write enable |
| res_addr | input | 11 | Result write address |
| res_data | input | 32 | Result write data |
| src_sel | input | 9 | Plain source operand selector |
| dst_sel | input | 9 | Plain destination operand selector |
| op_consume | input | 1 | The instruction is an ordinary one that consumes a prefix |
| ext_load | input | 1 | The instruction is a prefix |
| ext_src_from_reg | input | 1 | Prefix source address comes from the source operand |
| ext_dst_from_reg | input | 1 | Prefix destination address comes from the destination operand |
| ext_src_imm | input | 11 | Immediate prefix source address |
| ext_dst_imm | input | 11 | Immediate prefix destination address |
| instr_word | output | 32 | Fetched instruction word |
| src_word | output | 32 | Source operand word |
| dst_word | output | 32 | Destination operand word |

## Verification
The hardest case to reach is a register-sourced prefix that arrives while an earlier prefix is still pending. The prefix instruction has to read its own operands at plain addresses, ignoring the pending prefix, and then build the new addresses from those reads. The bench builds this in steps. It first writes a word whose low bits point into the upper space. It then arms an immediate prefix aimed somewhere else, issues the register-sourced prefix, and checks both the prefix instruction's own operands and the words a later consuming instruction receives. A single instruction that writes a word and also fetches and reads it tests the order of slots within the same pair of core cycles.

// File: rtl/dpump_pkg.sv
// Shared constants and the slot encoding for the double-pumped register file.
// Assumes one instruction spans four fast cycles in the fixed slot order below.
package dpump_pkg;
    localparam int DEF_DATA_W = 32;
    localparam int DEF_ADDR_W = 11;
    localparam int DEF_BASE_W = 9;

    // Slot order is behaviour: the fetch precedes the write, and the write precedes the operand reads.
    typedef enum logic [1:0] {
        SLOT_FETCH = 2'd0,
        SLOT_WRITE = 2'd1,
        SLOT_SRC   = 2'd2,
        SLOT_DST   = 2'd3
    } slot_e;
endpackage

// File: rtl/dpump_sched.sv
// Slot sequencer: steps through the four array slots, one per fast clock.
// Assumes a synchronous active-low reset that restarts the sequence at the fetch slot.
module dpump_sched
    import dpump_pkg::*;
(
    input  logic  clk2x,
    input  logic  rst_n,
    output slot_e slot
);
    logic [1:0] cnt_q;

    // Advance the slot counter on every fast edge.
    always_ff @(posedge clk2x) begin
        if (!rst_n) cnt_q <= 2'd0;
        else        cnt_q <= cnt_q + 2'd1;
    end

    assign slot = slot_e'(cnt_q);
endmodule

// File: rtl/dpump_array.sv
// Single-port storage: one address, one write enable, combinational read.
// Assumes at most one access per fast cycle. The contents have no reset.
module dpump_array #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 11
) (
    input  logic              clk2x,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Store the write data on the edge that ends the write slot.
    always_ff @(posedge clk2x) begin
        if (we) mem_q[addr] <= wdata;
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/dpump_prefix.sv
// Address-extension prefix latch: holds wide operand addresses for later instructions.
// Assumes commit pulses once per instruction, on the edge that ends the destination slot.
module dpump_prefix #(
    parameter int ADDR_W = 11
) (
    input  logic              clk2x,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              load,
    input  logic              consume,
    input  logic              src_from_reg,
    input  logic              dst_from_reg,
    input  logic [ADDR_W-1:0] src_imm,
    input  logic [ADDR_W-1:0] dst_imm,
    input  logic [ADDR_W-1:0] src_rd,
    input  logic [ADDR_W-1:0] dst_rd,
    output logic              valid,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);
    logic [ADDR_W-1:0] src_next;
    logic [ADDR_W-1:0] dst_next;

    // Pick each new address from the immediate or from the operand just read.
    always_comb begin
        src_next = src_from_reg ? src_rd : src_imm;
        dst_next = dst_from_reg ? dst_rd : dst_imm;
    end

    // Arm, replace or clear the prefix when an instruction ends.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            valid    <= 1'b0;
            src_addr <= '0;
            dst_addr <= '0;
        end else if (commit) begin
            if (load) begin
                valid    <= 1'b1;
                src_addr <= src_next;
                dst_addr <= dst_next;
            end else if (consume) begin
                valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dpump_regfile.sv
// Double-pumped register file top: four fixed slots on one single-port array,
// with core-rate output registers and an operand address-extension prefix.
// Assumes the core-rate inputs are held steady from slot 0 to slot 3 of each instruction.
module dpump_regfile
    import dpump_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int BASE_W = DEF_BASE_W
) (
    input  logic              clk2x,
    input  logic              rst_n,
    output logic              phase_sd,
    output logic              half_hi,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              res_we,
    input  logic [ADDR_W-1:0] res_addr,
    input  logic [DATA_W-1:0] res_data,
    input  logic [BASE_W-1:0] src_sel,
    input  logic [BASE_W-1:0] dst_sel,
    input  logic              op_consume,
    input  logic              ext_load,
    input  logic              ext_src_from_reg,
    input  logic              ext_dst_from_reg,
    input  logic [ADDR_W-1:0] ext_src_imm,
    input  logic [ADDR_W-1:0] ext_dst_imm,
    output logic [DATA_W-1:0] instr_word,
    output logic [DATA_W-1:0] src_word,
    output logic [DATA_W-1:0] dst_word
);
    localparam int PAD_W = ADDR_W - BASE_W;

    slot_e             slot;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_addr;
    logic [DATA_W-1:0] arr_rdata;
    logic [DATA_W-1:0] instr_stage_q;
    logic [DATA_W-1:0] src_stage_q;
    logic              pfx_valid;
    logic [ADDR_W-1:0] pfx_src;
    logic [ADDR_W-1:0] pfx_dst;
    logic              use_pfx;
    logic [ADDR_W-1:0] eff_src;
    logic [ADDR_W-1:0] eff_dst;

    dpump_sched sched_i (
        .clk2x (clk2x),
        .rst_n (rst_n),
        .slot  (slot)
    );

    assign phase_sd = slot[1];
    assign half_hi  = slot[0];

    // Choose the operand addresses: a pending prefix, except for a prefix instruction itself.
    always_comb begin
        use_pfx = pfx_valid && !ext_load;
        eff_src = use_pfx ? pfx_src : {{PAD_W{1'b0}}, src_sel};
        eff_dst = use_pfx ? pfx_dst : {{PAD_W{1'b0}}, dst_sel};
    end

    // Drive the single array port from the access the current slot owns.
    always_comb begin
        arr_we = 1'b0;
        unique case (slot)
            SLOT_FETCH: arr_addr = fetch_addr;
            SLOT_WRITE: begin
                arr_addr = res_addr;
                arr_we   = res_we;
            end
            SLOT_SRC:   arr_addr = eff_src;
            SLOT_DST:   arr_addr = eff_dst;
            default:    arr_addr = fetch_addr;
        endcase
    end

    dpump_array #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) array_i (
        .clk2x (clk2x),
        .we    (arr_we),
        .addr  (arr_addr),
        .wdata (res_data),
        .rdata (arr_rdata)
    );

    dpump_prefix #(
        .ADDR_W (ADDR_W)
    ) prefix_i (
        .clk2x        (clk2x),
        .rst_n        (rst_n),
        .commit       (slot == SLOT_DST),
        .load         (ext_load),
        .consume      (op_consume),
        .src_from_reg (ext_src_from_reg),
        .dst_from_reg (ext_dst_from_reg),
        .src_imm      (ext_src_imm),
        .dst_imm      (ext_dst_imm),
        .src_rd       (src_stage_q[ADDR_W-1:0]),
        .dst_rd       (arr_rdata[ADDR_W-1:0]),
        .valid        (pfx_valid),
        .src_addr     (pfx_src),
        .dst_addr     (pfx_dst)
    );

    // Stage first-half reads, then publish them at core-cycle boundaries.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            instr_stage_q <= '0;
            src_stage_q   <= '0;
            instr_word    <= '0;
            src_word      <= '0;
            dst_word      <= '0;
        end else begin
            unique case (slot)
                SLOT_FETCH: instr_stage_q <= arr_rdata;
                SLOT_WRITE: instr_word    <= instr_stage_q;
                SLOT_SRC:   src_stage_q   <= arr_rdata;
                SLOT_DST: begin
                    src_word <= src_stage_q;
                    dst_word <= arr_rdata;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dpump_regfile_chk.sv
// Checker for the double-pumped register file: slot order, output holding and prefix lifetime.
// Assumes it is bound to dpump_regfile and sees that module's internal write strobe and prefix flag.
module dpump_regfile_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk2x,
    input logic              rst_n,
    input logic              phase_sd,
    input logic              half_hi,
    input logic              arr_we,
    input logic              pfx_valid,
    input logic              ext_load,
    input logic              op_consume,
    input logic [DATA_W-1:0] instr_word,
    input logic [DATA_W-1:0] src_word,
    input logic [DATA_W-1:0] dst_word
);
    logic past_ok;

    // Mark that at least one edge has passed since reset was released.
    always_ff @(posedge clk2x) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_half_toggle_R2: assert property (@(posedge clk2x) disable iff (!rst_n)
        past_ok |-> (half_hi != $past(half_hi)));

    assert_phase_step_R2: assert property (@(posedge clk2x) disable iff (!rst_n)
        past_ok |-> ((phase_sd != $past(phase_sd)) == $past(half_hi)));

    assert_write_slot_R13: assert property (@(posedge clk2x) disable iff (!rst_n)
        arr_we |-> (half_hi && !phase_sd));

    assert_instr_hold_R5: assert property (@(posedge clk2x) disable iff (!rst_n)
        (past_ok && !($past(half_hi) && !$past(phase_sd))) |-> $stable(instr_word));

    assert_oper_hold_R4: assert property (@(posedge clk2x) disable iff (!rst_n)
        (past_ok && !($past(half_hi) && $past(phase_sd))) |-> ($stable(src_word) && $stable(dst_word)));

    assert_pfx_arm_R8: assert property (@(posedge clk2x) disable iff (!rst_n)
        (past_ok && $past(half_hi && phase_sd && ext_load)) |-> pfx_valid);

    assert_pfx_clear_R9: assert property (@(posedge clk2x) disable iff (!rst_n)
        (past_ok && $past(half_hi && phase_sd && op_consume && !ext_load)) |-> !pfx_valid);

    assert_pfx_reset_R12: assert property (@(posedge clk2x) disable iff (!rst_n)
        !past_ok |-> !pfx_valid);
endmodule

bind dpump_regfile dpump_regfile_chk #(.DATA_W(DATA_W)) chk_i (
    .clk2x      (clk2x),
    .rst_n      (rst_n),
    .phase_sd   (phase_sd),
    .half_hi    (half_hi),
    .arr_we     (arr_we),
    .pfx_valid  (pfx_valid),
    .ext_load   (ext_load),
    .op_consume (op_consume),
    .instr_word (instr_word),
    .src_word   (src_word),
    .dst_word   (dst_word)
);

// File: tb/dpump_regfile_tb_top.sv
`timescale 1ns/1ps
// Directed bench for dpump_regfile: one task per scenario, each checking its own results.
module dpump_regfile_tb_top;
    logic        clk2x = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase_sd, half_hi;
    logic [10:0] fetch_addr = '0;
    logic        res_we = 1'b0;
    logic [10:0] res_addr = '0;
    logic [31:0] res_data = '0;
    logic [8:0]  src_sel = '0, dst_sel = '0;
    logic        op_consume = 1'b0, ext_load = 1'b0;
    logic        ext_src_from_reg = 1'b0, ext_dst_from_reg = 1'b0;
    logic [10:0] ext_src_imm = '0, ext_dst_imm = '0;
    logic [31:0] instr_word, src_word, dst_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [31:0] VA = 32'h1234_0345;
    localparam logic [31:0] VB = 32'hBEEF_0004;
    localparam logic [31:0] VC = 32'hC0DE_0600;
    localparam logic [31:0] VD = 32'hDDDD_07FF;
    localparam logic [31:0] VE = 32'hEEEE_0400;
    localparam logic [31:0] VF = 32'hF00D_01FF;
    localparam logic [31:0] VG = 32'h6666_05FF;
    localparam logic [31:0] VH = 32'h5A5A_A5A5;
    localparam logic [31:0] VJ = 32'h0345_0345;
    localparam logic [31:0] VP = 32'h0000_0600;

    always #2.5 clk2x = ~clk2x;

    dpump_regfile dut_i (
        .clk2x(clk2x), .rst_n(rst_n), .phase_sd(phase_sd), .half_hi(half_hi),
        .fetch_addr(fetch_addr), .res_we(res_we), .res_addr(res_addr), .res_data(res_data),
        .src_sel(src_sel), .dst_sel(dst_sel), .op_consume(op_consume), .ext_load(ext_load),
        .ext_src_from_reg(ext_src_from_reg), .ext_dst_from_reg(ext_dst_from_reg),
        .ext_src_imm(ext_src_imm), .ext_dst_imm(ext_dst_imm),
        .instr_word(instr_word), .src_word(src_word), .dst_word(dst_word)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic to_slot0();
        while (!(phase_sd == 1'b0 && half_hi == 1'b0)) @(negedge clk2x);
    endtask

    // Drive one full instruction from slot 0 and return at the next slot-0 negedge.
    task automatic instr(input logic [10:0] f, input bit we, input logic [10:0] wa, input logic [31:0] wd,
                         input logic [8:0] ss, input logic [8:0] ds, input bit use_op, input bit pl,
                         input bit psr, input bit pdr, input logic [10:0] psi, input logic [10:0] pdi);
        to_slot0();
        fetch_addr = f; res_we = we; res_addr = wa; res_data = wd;
        src_sel = ss; dst_sel = ds; op_consume = use_op; ext_load = pl;
        ext_src_from_reg = psr; ext_dst_from_reg = pdr; ext_src_imm = psi; ext_dst_imm = pdi;
        repeat (4) @(negedge clk2x);
        res_we = 1'b0; ext_load = 1'b0; op_consume = 1'b0;
    endtask

    task automatic wr(input logic [10:0] a, input logic [31:0] d);
        instr(11'd0, 1'b1, a, d, 9'd0, 9'd0, 1'b0, 1'b0, 1'b0, 1'b0, 11'd0, 11'd0);
    endtask

    task automatic rd(input logic [8:0] ss, input logic [8:0] ds, input bit use_op);
        instr(11'd0, 1'b0, 11'd0, 32'd0, ss, ds, use_op, 1'b0, 1'b0, 1'b0, 11'd0, 11'd0);
    endtask

    task automatic pfx_imm(input logic [10:0] si, input logic [10:0] di);
        instr(11'd0, 1'b0, 11'd0, 32'd0, 9'd0, 9'd0, 1'b0, 1'b1, 1'b0, 1'b0, si, di);
    endtask

    task automatic t_reset();
        @(negedge clk2x);
        chk("R1", "phase_sd in reset", {31'd0, phase_sd}, 32'd0);
        chk("R1", "half_hi in reset", {31'd0, half_hi}, 32'd0);
        chk("R1", "instr_word in reset", instr_word, 32'd0);
        chk("R1", "src_word in reset", src_word, 32'd0);
        chk("R1", "dst_word in reset", dst_word, 32'd0);
        rst_n = 1'b1;
        #0.1;
        chk("R1", "slot after release", {30'd0, phase_sd, half_hi}, 32'd0);
    endtask

    task automatic t_schedule();
        to_slot0();
        for (int i = 0; i < 8; i++) begin
            chk("R2", "schedule slot", {30'd0, phase_sd, half_hi}, 32'(i % 4));
            @(negedge clk2x);
        end
    endtask

    task automatic t_fill_read();
        wr(11'h003, VA); wr(11'h004, VB); wr(11'h005, VP); wr(11'h600, VC);
        wr(11'h7FF, VD); wr(11'h400, VE); wr(11'h1FF, VF); wr(11'h5FF, VG); wr(11'h345, VJ);
        rd(9'h003, 9'h004, 1'b1);
        chk("R4", "src read", src_word, VA);
        chk("R4", "dst read", dst_word, VB);
        instr(11'd0, 1'b0, 11'h003, 32'hBAD0_BAD0, 9'h003, 9'h003, 1'b1, 1'b0, 1'b0, 1'b0, 11'd0, 11'd0);
        chk("R3", "disabled write ignored", src_word, VA);
        rd(9'h1FF, 9'h005, 1'b1);
        chk("R7", "plain selector zero-extended", src_word, VF);
        chk("R7", "plain dst selector", dst_word, VP);
    endtask

    task automatic t_fetch();
        instr(11'h7FF, 1'b0, 11'd0, 32'd0, 9'd0, 9'd0, 1'b0, 1'b0, 1'b0, 1'b0, 11'd0, 11'd0);
        chk("R5", "fetch top word", instr_word, VD);
        instr(11'h003, 1'b0, 11'd0, 32'd0, 9'd0, 9'd0, 1'b0, 1'b0, 1'b0, 1'b0, 11'd0, 11'd0);
        chk("R5", "fetch low word", instr_word, VA);
    endtask

    task automatic t_order();
        instr(11'h004, 1'b1, 11'h004, VH, 9'h004, 9'h004, 1'b1, 1'b0, 1'b0, 1'b0, 11'd0, 11'd0);
        chk("R6", "fetch sees old word", instr_word, VB);
        chk("R6", "src sees new word", src_word, VH);
        chk("R6", "dst sees new word", dst_word, VH);
    endtask

    task automatic t_hold();
        instr(11'h003, 1'b0, 11'd0, 32'd0, 9'h003, 9'h005, 1'b1, 1'b0, 1'b0, 1'b0, 11'd0, 11'd0);
        fetch_addr = 11'h7FF; src_sel = 9'h1FF; dst_sel = 9'h004;
        @(negedge clk2x);
        chk("R5", "instr held in slot 1", instr_word, VA);
        chk("R4", "src held in slot 1", src_word, VA);
        @(negedge clk2x);
        chk("R5", "instr updated after slot 1", instr_word, VD);
        chk("R4", "src held in slot 2", src_word, VA);
        @(negedge clk2x);
        chk("R4", "dst held in slot 3", dst_word, VP);
        @(negedge clk2x);
        chk("R4", "src updated after slot 3", src_word, VF);
        chk("R4", "dst updated after slot 3", dst_word, VH);
        chk("R5", "instr held over operand cycle", instr_word, VD);
    endtask

    task automatic t_prefix_imm();
        pfx_imm(11'h7FF, 11'h400);
        rd(9'h003, 9'h004, 1'b0);
        chk("R8", "prefix src applies", src_word, VD);
        chk("R8", "prefix dst applies", dst_word, VE);
        rd(9'h000, 9'h000, 1'b1);
        chk("R9", "prefix kept by non-consumer", src_word, VD);
        chk("R9", "prefix kept dst", dst_word, VE);
        rd(9'h003, 9'h004, 1'b1);
        chk("R9", "prefix cleared src", src_word, VA);
        chk("R9", "prefix cleared dst", dst_word, VH);
    endtask

    task automatic t_prefix_reg();
        pfx_imm(11'h7FF, 11'h7FF);
        instr(11'd0, 1'b0, 11'd0, 32'd0, 9'h005, 9'h003, 1'b0, 1'b1, 1'b1, 1'b1, 11'h000, 11'h000);
        chk("R10", "prefix own src plain", src_word, VP);
        chk("R10", "prefix own dst plain", dst_word, VA);
        rd(9'h000, 9'h000, 1'b1);
        chk("R10", "register-sourced src", src_word, VC);
        chk("R10", "register-sourced dst", dst_word, VJ);
    endtask

    task automatic t_replace();
        pfx_imm(11'h7FF, 11'h7FF);
        pfx_imm(11'h600, 11'h400);
        rd(9'h000, 9'h000, 1'b1);
        chk("R11", "second prefix src wins", src_word, VC);
        chk("R11", "second prefix dst wins", dst_word, VE);
    endtask

    task automatic t_reset_clear();
        pfx_imm(11'h7FF, 11'h600);
        @(negedge clk2x);
        rst_n = 1'b0;
        repeat (2) @(negedge clk2x);
        chk("R1", "src zero in second reset", src_word, 32'd0);
        rst_n = 1'b1;
        rd(9'h003, 9'h005, 1'b1);
        chk("R12", "reset cleared prefix src", src_word, VA);
        chk("R12", "reset cleared prefix dst", dst_word, VP);
    endtask

    initial begin
        t_reset();
        t_schedule();
        t_fill_read();
        t_fetch();
        t_order();
        t_hold();
        t_prefix_imm();
        t_prefix_reg();
        t_replace();
        t_reset_clear();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule